// File: doc/BRIEF.md
# Serial RGB LCD Sync Generator

This block produces the line and frame timing for a small serial-RGB LCD panel, clocked directly by the pixel-port clock. Every pixel is sent as three colour bytes on consecutive clock ticks. The block drives an active-low horizontal sync, an active-low vertical sync, a data-enable window covering the active bytes of each line, and the current line and pixel-column numbers. A pixel feeder uses these to decide when to present data.

After reset the block stays idle with both syncs inactive. A start pulse launches the vertical generator first. The horizontal generator follows a fixed, parameterised number of ticks later, so that the frame sync always leads the line sync. The frame period is a whole number of line periods, so the two generators stay in lock without drift. The first line of each frame is a blanking line and carries no data. The other lines open their data window a fixed number of ticks after the line sync begins.

All timing values are parameters. The defaults are 320 pixels of 3 ticks each, a 1224-tick line with a 90-tick sync pulse, and a window opening 204 ticks after the sync edge. A frame is one blanking line plus 240 active lines, and the frame sync is 3 lines long.

Top module: `rgb_lcd_sync`

## Requirements
- R1: While `rst` is high at a clock edge, and at every later edge until `start` is accepted, the outputs are `hs_n_o`=1, `vs_n_o`=1, `de_o`=0, `line_o`=0 and `col_o`=0.
- R2: When `start` is sampled high at edge k while the block is idle, `vs_n_o` goes low after edge k+1. `hs_n_o` first goes low after edge k+1+H_LAG, so the frame sync leads the line sync by H_LAG ticks.
- R3: Once running, `hs_n_o` is low for H_PULSE ticks at the start of each line and high for the rest of it. The line lasts H_PERIOD_PIX×TICKS_PER_PIX ticks.
- R4: On a non-blanking line, `de_o` is high for exactly H_PIXELS×TICKS_PER_PIX consecutive ticks. The window begins H_START ticks after `hs_n_o` falls, and `hs_n_o` is high whenever `de_o` is high.
- R5: While `de_o` is high, `col_o` gives the pixel index. It starts at 0 and advances by one every TICKS_PER_PIX ticks. Outside the window `col_o` is 0.
- R6: `line_o` changes only in the tick where `hs_n_o` falls. It counts 0 to V_ACTIVE+V_BLANK−1 and then wraps to 0.
- R7: Lines with `line_o` below V_BLANK (line 0 by default) are blanking lines, and on them `de_o` stays low even inside the horizontal window.
- R8: `vs_n_o` repeats every (V_ACTIVE+V_BLANK) line periods and is low for V_PULSE_LINES line periods. It falls H_LAG ticks before the line-0 fall of `hs_n_o`, with no drift across frames.
- R9: A `start` pulse while the block is running has no effect on any output.
- R10: A synchronous reset in mid-frame returns the block to the idle state of R1. A later `start` restarts the timing as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-port clock, one tick per colour byte |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches the generators when idle |
| hs_n_o | output | 1 | Line sync, active low |
| vs_n_o | output | 1 | Frame sync, active low |
| de_o | output | 1 | Data-enable window for active bytes |
| line_o | output | clog2(V_ACTIVE+V_BLANK) | Current line number, 0 is blanking |
| col_o | output | clog2(H_PIXELS) | Pixel index inside the data window |

## Verification
The bench runs the generator with small timing parameters so that several full frames fit into a short run. A behavioural model works out every output from the number of ticks since start, and the outputs are compared with it on every clock. A long idle stretch before the first start separates a generator that free-runs from one that waits to be armed. The run after the first start covers several frame wraps, which exposes drift between the two syncs and errors in the blanking line. A stray start pulse in mid-frame shows whether a running generator can be re-armed when it should not be. A reset in mid-frame followed by a second start checks that every counter is cleared and that the sync ordering comes back as before.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_VLEAD = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/lcd_seq.sv
module lcd_seq
  import lcd_sync_pkg::*;
#(
  parameter int VW    = 19,
  parameter int H_LAG = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [VW-1:0] v_cnt,
  output logic          v_load,
  output logic          v_run,
  output logic          h_load,
  output logic          h_run
);
  localparam logic [VW-1:0] LAG_LAST = VW'(H_LAG - 1);

  seq_state_e st;

  assign v_load = (st == SEQ_IDLE) && start;
  assign h_load = (st == SEQ_VLEAD) && (v_cnt == LAG_LAST);
  assign v_run  = (st != SEQ_IDLE);
  assign h_run  = (st == SEQ_RUN);

  always_ff @(posedge clk) begin
    if (rst)         st <= SEQ_IDLE;
    else if (v_load) st <= SEQ_VLEAD;
    else if (h_load) st <= SEQ_RUN;
  end
endmodule

// File: rtl/lcd_vtimer.sv
module lcd_vtimer #(
  parameter int V_PER = 294984,
  parameter int V_PW  = 3672,
  parameter int VW    = 19
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          run,
  output logic [VW-1:0] cnt,
  output logic          sync
);
  localparam logic [VW-1:0] LAST = VW'(V_PER - 1);
  localparam logic [VW-1:0] PW   = VW'(V_PW);

  assign sync = run && (cnt < PW);

  always_ff @(posedge clk) begin
    if (rst || load) cnt <= '0;
    else if (run)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/lcd_htimer.sv
module lcd_htimer #(
  parameter int H_PER   = 1224,
  parameter int H_PW    = 90,
  parameter int V_LINES = 241,
  parameter int HW      = 11,
  parameter int LW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          run,
  output logic [HW-1:0] h_cnt,
  output logic [HW-1:0] h_nxt,
  output logic [LW-1:0] line,
  output logic          sync
);
  localparam logic [HW-1:0] H_LAST = HW'(H_PER - 1);
  localparam logic [HW-1:0] PW     = HW'(H_PW);
  localparam logic [LW-1:0] L_LAST = LW'(V_LINES - 1);

  assign sync = run && (h_cnt < PW);

  always_comb begin
    if (load)     h_nxt = '0;
    else if (run) h_nxt = (h_cnt == H_LAST) ? '0 : h_cnt + 1'b1;
    else          h_nxt = h_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) h_cnt <= '0;
    else     h_cnt <= h_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst || load)
      line <= '0;
    else if (run && (h_cnt == H_LAST))
      line <= (line == L_LAST) ? '0 : line + 1'b1;
  end
endmodule

// File: rtl/lcd_window.sv
module lcd_window #(
  parameter int TPP     = 3,
  parameter int H_START = 204,
  parameter int H_ACT   = 960,
  parameter int V_BLANK = 1,
  parameter int HW      = 11,
  parameter int LW      = 8,
  parameter int CW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [HW-1:0] h_cnt,
  input  logic [HW-1:0] h_nxt,
  input  logic [LW-1:0] line,
  output logic          de,
  output logic [CW-1:0] pix
);
  localparam logic [HW-1:0] WIN_LO = HW'(H_START);
  localparam logic [HW-1:0] WIN_HI = HW'(H_START + H_ACT);
  localparam logic [LW-1:0] BLANK  = LW'(V_BLANK);

  logic in_win;
  logic win_open;

  assign in_win   = run && (h_cnt >= WIN_LO) && (h_cnt < WIN_HI);
  assign de       = in_win && (line >= BLANK);
  assign win_open = (h_nxt == WIN_LO);

  generate
    if (TPP > 1) begin : g_multi_tick
      localparam int SW = $clog2(TPP);
      localparam logic [SW-1:0] SUB_LAST = SW'(TPP - 1);
      logic [SW-1:0] sub;

      always_ff @(posedge clk) begin
        if (rst || win_open) begin
          sub <= '0;
          pix <= '0;
        end else if (in_win) begin
          if (sub == SUB_LAST) begin
            sub <= '0;
            pix <= pix + 1'b1;
          end else begin
            sub <= sub + 1'b1;
          end
        end
      end
    end else begin : g_single_tick
      always_ff @(posedge clk) begin
        if (rst || win_open) pix <= '0;
        else if (in_win)     pix <= pix + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/rgb_lcd_sync.sv
module rgb_lcd_sync #(
  parameter int TICKS_PER_PIX = 3,
  parameter int H_PIXELS      = 320,
  parameter int H_PERIOD_PIX  = 408,
  parameter int H_PULSE       = 90,
  parameter int H_START       = 204,
  parameter int V_ACTIVE      = 240,
  parameter int V_BLANK       = 1,
  parameter int V_PULSE_LINES = 3,
  parameter int H_LAG         = 1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 start,
  output logic                                 hs_n_o,
  output logic                                 vs_n_o,
  output logic                                 de_o,
  output logic [$clog2(V_ACTIVE+V_BLANK)-1:0]  line_o,
  output logic [$clog2(H_PIXELS)-1:0]          col_o
);
  localparam int H_ACT   = H_PIXELS * TICKS_PER_PIX;
  localparam int H_PER   = H_PERIOD_PIX * TICKS_PER_PIX;
  localparam int V_LINES = V_ACTIVE + V_BLANK;
  localparam int V_PER   = H_PER * V_LINES;
  localparam int V_PW    = V_PULSE_LINES * H_PER;
  localparam int HW      = $clog2(H_PER + 1);
  localparam int VW      = $clog2(V_PER + 1);
  localparam int LW      = $clog2(V_LINES);
  localparam int CW      = $clog2(H_PIXELS);

  logic          v_load, v_run, h_load, h_run;
  logic [VW-1:0] v_cnt;
  logic          v_sync, h_sync;
  logic [HW-1:0] h_cnt, h_nxt;
  logic [LW-1:0] line;
  logic          de;
  logic [CW-1:0] pix;

  lcd_seq #(.VW(VW), .H_LAG(H_LAG)) u_seq (
    .clk(clk), .rst(rst), .start(start), .v_cnt(v_cnt),
    .v_load(v_load), .v_run(v_run), .h_load(h_load), .h_run(h_run)
  );

  lcd_vtimer #(.V_PER(V_PER), .V_PW(V_PW), .VW(VW)) u_vtim (
    .clk(clk), .rst(rst), .load(v_load), .run(v_run),
    .cnt(v_cnt), .sync(v_sync)
  );

  lcd_htimer #(.H_PER(H_PER), .H_PW(H_PULSE), .V_LINES(V_LINES),
               .HW(HW), .LW(LW)) u_htim (
    .clk(clk), .rst(rst), .load(h_load), .run(h_run),
    .h_cnt(h_cnt), .h_nxt(h_nxt), .line(line), .sync(h_sync)
  );

  lcd_window #(.TPP(TICKS_PER_PIX), .H_START(H_START), .H_ACT(H_ACT),
               .V_BLANK(V_BLANK), .HW(HW), .LW(LW), .CW(CW)) u_win (
    .clk(clk), .rst(rst), .run(h_run), .h_cnt(h_cnt), .h_nxt(h_nxt),
    .line(line), .de(de), .pix(pix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_n_o <= 1'b1;
      vs_n_o <= 1'b1;
      de_o   <= 1'b0;
      line_o <= '0;
      col_o  <= '0;
    end else begin
      hs_n_o <= ~h_sync;
      vs_n_o <= ~v_sync;
      de_o   <= de;
      line_o <= line;
      col_o  <= de ? pix : '0;
    end
  end
endmodule

// File: rtl/lcd_sync_chk.sv
module lcd_sync_chk #(
  parameter int LW      = 8,
  parameter int CW      = 9,
  parameter int V_BLANK = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          hs_n,
  input logic          vs_n,
  input logic          de,
  input logic [LW-1:0] line,
  input logic [CW-1:0] col
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (hs_n && vs_n && !de && line == '0 && col == '0));

  // R4
  window_after_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    de |-> hs_n);

  // R7
  blank_line_chk: assert property (@(posedge clk) disable iff (rst)
    de |-> (line >= LW'(V_BLANK)));

  // R5
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (de && $past(de)) |-> (col == $past(col) || col == CW'($past(col) + 1'b1)));

  // R6
  line_moves_on_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(line)) |-> $fell(hs_n));

  // R8
  frame_leads_line_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(vs_n) |-> hs_n);
endmodule

bind rgb_lcd_sync lcd_sync_chk #(.LW(LW), .CW(CW), .V_BLANK(V_BLANK)) u_chk (
  .clk(clk), .rst(rst), .hs_n(hs_n_o), .vs_n(vs_n_o), .de(de_o),
  .line(line_o), .col(col_o)
);

// File: tb/rgb_lcd_sync_test.sv
module rgb_lcd_sync_test;
  localparam int CLK_PERIOD = 10;
  localparam int TPP   = 3;
  localparam int HPIX  = 4;
  localparam int HPP   = 9;
  localparam int HPW   = 5;
  localparam int HST   = 8;
  localparam int VACT  = 4;
  localparam int VB    = 1;
  localparam int VPL   = 2;
  localparam int LAG   = 1;
  localparam int HP    = HPP * TPP;
  localparam int HACT  = HPIX * TPP;
  localparam int VL    = VACT + VB;
  localparam int VP    = HP * VL;
  localparam int VPW   = VPL * HP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic hs_n, vs_n, de;
  logic [$clog2(VL)-1:0]   line;
  logic [$clog2(HPIX)-1:0] col;

  rgb_lcd_sync #(
    .TICKS_PER_PIX(TPP), .H_PIXELS(HPIX), .H_PERIOD_PIX(HPP), .H_PULSE(HPW),
    .H_START(HST), .V_ACTIVE(VACT), .V_BLANK(VB), .V_PULSE_LINES(VPL), .H_LAG(LAG)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .hs_n_o(hs_n), .vs_n_o(vs_n),
    .de_o(de), .line_o(line), .col_o(col)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit armed = 1'b0;
  string tag_ovr = "";

  int since = -1;
  int e_hs = 1, e_vs = 1, e_de = 0, e_line = 0, e_col = 0;
  bit e_idle = 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: outputs after an edge follow the tick count before it
  always @(posedge clk) begin
    int p, q, h, ln;
    p = since;
    e_hs = 1; e_vs = 1; e_de = 0; e_line = 0; e_col = 0; e_idle = 1'b1;
    if (!rst && p >= 0) begin
      e_idle = 1'b0;
      e_vs = ((p % VP) < VPW) ? 0 : 1;
      q = p - LAG;
      if (q >= 0) begin
        h  = q % HP;
        ln = (q / HP) % VL;
        e_hs   = (h < HPW) ? 0 : 1;
        e_de   = (h >= HST && h < HST + HACT && ln >= VB) ? 1 : 0;
        e_col  = e_de ? (h - HST) / TPP : 0;
        e_line = ln;
      end
    end
    if (rst)                      since = -1;
    else if (since < 0 && start)  since = 0;
    else if (since >= 0)          since = since + 1;
    armed = 1'b1;
  end

  always @(negedge clk) begin
    if (armed && !done) begin
      string th, tv, td, tl, tc;
      th = "R3"; tv = "R8"; td = (e_line < VB) ? "R7" : "R4"; tl = "R6"; tc = "R5";
      if (e_idle) begin th = "R1"; tv = "R1"; td = "R1"; tl = "R1"; tc = "R1"; end
      if (tag_ovr != "") begin th = tag_ovr; tv = tag_ovr; td = tag_ovr; tl = tag_ovr; tc = tag_ovr; end
      check(hs_n == e_hs[0], th, hs_n, e_hs);
      check(vs_n == e_vs[0], tv, vs_n, e_vs);
      check(de == e_de[0], td, de, e_de);
      check(int'(line) == e_line, tl, line, e_line);
      check(int'(col) == e_col, tc, col, e_col);
    end
  end

  task automatic launch_and_check_order();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check(vs_n == 1'b0, "R2", vs_n, 0);
    check(hs_n == 1'b1, "R2", hs_n, 1);
    repeat (LAG) @(negedge clk);
    check(hs_n == 1'b0, "R2", hs_n, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (12) @(negedge clk);
    launch_and_check_order();
    repeat (3 * VP + 7) @(negedge clk);
    tag_ovr = "R9";
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2 * HP) @(negedge clk);
    tag_ovr = "";
    repeat (VP) @(negedge clk);
    rst = 1'b1;
    tag_ovr = "R10";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    tag_ovr = "";
    launch_and_check_order();
    repeat (2 * VP + 5) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule